// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block runs the fixed start-up sequence a processor core needs after any reset. A reset controller hands it a one-cycle start pulse and a cause bit: power-on or manual. The block then issues two word reads to the exception vector table over a simple request/response memory port. The first read returns the initial program counter and the second returns the initial stack pointer. The word addresses depend on the cause. Apart from those addresses, both causes run the same sequence.

At the start the block clears the vector base register and sets every bit of the interrupt mask field. While the reads are in flight it keeps the fetched program counter in a staging register. The architectural program counter and stack pointer do not change until the second read returns. Then both are loaded on the same clock edge, a one-cycle run pulse is raised and the hold on the core is released. A new start pulse in the middle of a sequence abandons it and begins again with the program-counter read for the new cause.

Top module: `reset_vector_sequencer`

## Requirements
- R1: While and after reset, hold_o is 1, run_o is 0, mem_req_o is 0, pc_o and sp_o are 0, vbr_o is 0 and imask_o is 4'b1111.
- R2: In the cycle after a start pulse, mem_req_o is 1 and mem_addr_o is the program-counter vector: 0x0 when cause_i was 0 (power-on) or 0x8 when cause_i was 1 (manual).
- R3: After the program-counter response, the block requests the stack-pointer vector at the program-counter vector address plus 4. While a read waits for mem_rvalid_i, mem_req_o and mem_addr_o stay unchanged for any number of cycles.
- R4: In the cycle after a start pulse, vbr_o is 0x00000000 and imask_o is 4'b1111.
- R5: pc_o and sp_o change only in the cycle where run_o is 1. They change together, to the data of the first read and of the second read.
- R6: run_o is 1 for exactly one cycle, the cycle after the stack-pointer response. hold_o falls in that same cycle and stays 0 until the next start pulse.
- R7: hold_o is 1 from the cycle after a start pulse until run_o is asserted, including every cycle in which mem_req_o is 1.
- R8: A start pulse during a sequence restarts the sequence at the program-counter read for the new cause and discards data already fetched. A start pulse wins over a response in the same cycle.
- R9: mem_rvalid_i while no read is outstanding is ignored: pc_o, sp_o, run_o and mem_req_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins the sequence |
| cause_i | input | 1 | Reset cause with the start pulse: 0 power-on, 1 manual |
| mem_req_o | output | 1 | Read request, held until answered |
| mem_addr_o | output | ADDR_W | Vector word address being read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| pc_o | output | DATA_W | Committed program counter |
| sp_o | output | DATA_W | Committed stack pointer |
| vbr_o | output | DATA_W | Vector base register |
| imask_o | output | MASK_W | Interrupt mask field of the status register |
| hold_o | output | 1 | Keeps the core stalled while high |
| run_o | output | 1 | One-cycle pulse: registers committed, core may execute |

## Verification
The hardest case to reach is a restart that collides with the sequence at its most delicate points. One is a start pulse arriving while the stack-pointer read is pending, after a program counter has already been staged. The other is a start pulse arriving in the very cycle the stack-pointer response lands. The bench drives both cases on purpose, switching the cause as it does. It then confirms that no run pulse escapes, that the request falls back to the new program-counter vector, and that the committed values come only from the restarted reads. A sweep over both causes and every pair of response latencies from zero to three cycles covers the waiting behaviour.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GET_PC = 2'd1,
        ST_GET_SP = 2'd2
    } rvs_state_e;

    localparam logic CAUSE_POWER_ON = 1'b0;
    localparam logic CAUSE_MANUAL   = 1'b1;

endpackage

// File: rtl/rvs_vec_addr.sv
module rvs_vec_addr #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned PO_BASE = 0,
    parameter int unsigned MR_BASE = 8,
    parameter int unsigned STRIDE  = 4
) (
    input  logic              cause_i,
    input  logic              sel_sp_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] PO_A   = ADDR_W'(PO_BASE);
    localparam logic [ADDR_W-1:0] MR_A   = ADDR_W'(MR_BASE);
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STRIDE);

    logic [ADDR_W-1:0] base;

    always_comb begin
        base   = (cause_i == rvs_pkg::CAUSE_MANUAL) ? MR_A : PO_A;
        addr_o = sel_sp_i ? (base + STEP_A) : base;
    end

endmodule

// File: rtl/rvs_ctrl.sv
module rvs_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cause_i,
    input  logic rvalid_i,
    output logic req_o,
    output logic sel_sp_o,
    output logic cause_o,
    output logic cap_pc_o,
    output logic commit_o,
    output logic hold_o,
    output logic run_o
);
    import rvs_pkg::*;

    typedef struct packed {
        rvs_state_e state;
        logic       cause;
        logic       hold;
        logic       run;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.run = 1'b0;
        cap_pc_o   = 1'b0;
        commit_o   = 1'b0;
        if (start_i) begin
            ctrl_d.state = ST_GET_PC;
            ctrl_d.cause = cause_i;
            ctrl_d.hold  = 1'b1;
        end else begin
            case (ctrl_q.state)
                ST_GET_PC: begin
                    if (rvalid_i) begin
                        cap_pc_o     = 1'b1;
                        ctrl_d.state = ST_GET_SP;
                    end
                end
                ST_GET_SP: begin
                    if (rvalid_i) begin
                        commit_o     = 1'b1;
                        ctrl_d.state = ST_IDLE;
                        ctrl_d.hold  = 1'b0;
                        ctrl_d.run   = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.state <= ST_IDLE;
            ctrl_q.cause <= CAUSE_POWER_ON;
            ctrl_q.hold  <= 1'b1;
            ctrl_q.run   <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign req_o    = (ctrl_q.state != ST_IDLE);
    assign sel_sp_o = (ctrl_q.state == ST_GET_SP);
    assign cause_o  = ctrl_q.cause;
    assign hold_o   = ctrl_q.hold;
    assign run_o    = ctrl_q.run;

endmodule

// File: rtl/rvs_regs.sv
module rvs_regs #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned MASK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cap_pc_i,
    input  logic              commit_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] pc_o,
    output logic [DATA_W-1:0] sp_o,
    output logic [DATA_W-1:0] vbr_o,
    output logic [MASK_W-1:0] imask_o
);

    typedef struct packed {
        logic [DATA_W-1:0] pc_stage;
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] sp;
        logic [DATA_W-1:0] vbr;
        logic [MASK_W-1:0] imask;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (start_i) begin
            regs_d.vbr   = '0;
            regs_d.imask = '1;
        end
        if (cap_pc_i) begin
            regs_d.pc_stage = rdata_i;
        end
        if (commit_i) begin
            regs_d.pc = regs_q.pc_stage;
            regs_d.sp = rdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.pc_stage <= '0;
            regs_q.pc       <= '0;
            regs_q.sp       <= '0;
            regs_q.vbr      <= '0;
            regs_q.imask    <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pc_o    = regs_q.pc;
    assign sp_o    = regs_q.sp;
    assign vbr_o   = regs_q.vbr;
    assign imask_o = regs_q.imask;

endmodule

// File: rtl/reset_vector_sequencer.sv
module reset_vector_sequencer #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned MASK_W  = 4,
    parameter int unsigned PO_BASE = 0,
    parameter int unsigned MR_BASE = 8,
    parameter int unsigned STRIDE  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cause_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] pc_o,
    output logic [DATA_W-1:0] sp_o,
    output logic [DATA_W-1:0] vbr_o,
    output logic [MASK_W-1:0] imask_o,
    output logic              hold_o,
    output logic              run_o
);

    logic sel_sp;
    logic cause_q;
    logic cap_pc;
    logic commit;

    rvs_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .cause_i  (cause_i),
        .rvalid_i (mem_rvalid_i),
        .req_o    (mem_req_o),
        .sel_sp_o (sel_sp),
        .cause_o  (cause_q),
        .cap_pc_o (cap_pc),
        .commit_o (commit),
        .hold_o   (hold_o),
        .run_o    (run_o)
    );

    rvs_vec_addr #(
        .ADDR_W  (ADDR_W),
        .PO_BASE (PO_BASE),
        .MR_BASE (MR_BASE),
        .STRIDE  (STRIDE)
    ) u_addr (
        .cause_i  (cause_q),
        .sel_sp_i (sel_sp),
        .addr_o   (mem_addr_o)
    );

    rvs_regs #(
        .DATA_W (DATA_W),
        .MASK_W (MASK_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .cap_pc_i (cap_pc),
        .commit_i (commit),
        .rdata_i  (mem_rdata_i),
        .pc_o     (pc_o),
        .sp_o     (sp_o),
        .vbr_o    (vbr_o),
        .imask_o  (imask_o)
    );

endmodule

// File: rtl/rvs_checker.sv
module rvs_checker #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned MASK_W  = 4,
    parameter int unsigned PO_BASE = 0,
    parameter int unsigned MR_BASE = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              cause_i,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_rvalid_i,
    input logic [DATA_W-1:0] pc_o,
    input logic [DATA_W-1:0] sp_o,
    input logic [DATA_W-1:0] vbr_o,
    input logic [MASK_W-1:0] imask_o,
    input logic              hold_o,
    input logic              run_o
);

    assert_first_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> mem_req_o &&
            (mem_addr_o == ($past(cause_i) ? ADDR_W'(MR_BASE) : ADDR_W'(PO_BASE))));

    assert_wait_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i && !start_i) |=> mem_req_o && $stable(mem_addr_o));

    assert_init_regs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (vbr_o == '0) && (imask_o == '1));

    assert_pc_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_o != $past(pc_o)) |-> run_o);

    assert_sp_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_o != $past(sp_o)) |-> run_o);

    assert_run_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |=> !run_o);

    assert_run_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> !hold_o && !mem_req_o);

    assert_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> hold_o);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req_o && !start_i) |=> !mem_req_o && !run_o);

endmodule

bind reset_vector_sequencer rvs_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MASK_W  (MASK_W),
    .PO_BASE (PO_BASE),
    .MR_BASE (MR_BASE)
) u_rvs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cause_i      (cause_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .pc_o         (pc_o),
    .sp_o         (sp_o),
    .vbr_o        (vbr_o),
    .imask_o      (imask_o),
    .hold_o       (hold_o),
    .run_o        (run_o)
);

// File: tb/tb_reset_vector_sequencer.sv
module tb_reset_vector_sequencer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic        cause_i;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_rvalid_i;
    logic [31:0] mem_rdata_i;
    logic [31:0] pc_o, sp_o, vbr_o;
    logic [3:0]  imask_o;
    logic        hold_o, run_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_vector_sequencer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cause_i      (cause_i),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .pc_o         (pc_o),
        .sp_o         (sp_o),
        .vbr_o        (vbr_o),
        .imask_o      (imask_o),
        .hold_o       (hold_o),
        .run_o        (run_o)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic c);
        start_i = 1'b1;
        cause_i = c;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic respond(input logic [31:0] d);
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = d;
        @(negedge clk);
        mem_rvalid_i = 1'b0;
        mem_rdata_i  = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] cur_pc;
        logic [31:0] cur_sp;
        int          iter;

        rst_n        = 1'b0;
        start_i      = 1'b0;
        cause_i      = 1'b0;
        mem_rvalid_i = 1'b0;
        mem_rdata_i  = '0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(hold_o && !run_o && !mem_req_o, "R1 ctl in reset", {hold_o, run_o, mem_req_o}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pc_o == 0 && sp_o == 0, "R1 pc/sp", pc_o ^ sp_o, 0);
        chk(vbr_o == 0 && imask_o == 4'hF, "R1 vbr/imask", {vbr_o[27:0], imask_o}, 32'h0000000F);
        chk(hold_o && !run_o && !mem_req_o, "R1 ctl", {hold_o, run_o, mem_req_o}, 3'b100);

        // R9 stray response while idle
        respond(32'hDEAD_BEEF);
        chk(pc_o == 0 && sp_o == 0, "R9 pc/sp unchanged", pc_o | sp_o, 0);
        chk(!run_o && !mem_req_o, "R9 no run/req", {run_o, mem_req_o}, 0);
        @(negedge clk);
        chk(!run_o && !mem_req_o && pc_o == 0, "R9 still idle", {run_o, mem_req_o}, 0);

        cur_pc = 0;
        cur_sp = 0;
        iter   = 0;
        for (int c = 0; c < 2; c++) begin
            for (int lp = 0; lp < 4; lp++) begin
                for (int ls = 0; ls < 4; ls++) begin
                    logic [31:0] base, pcv, spv;
                    base = (c == 1) ? 32'h8 : 32'h0;
                    pcv  = 32'h1000_0000 + (iter << 8) + base;
                    spv  = 32'h2000_0000 + (iter << 8) + base + 4;
                    pulse_start(c[0]);
                    chk(mem_req_o && mem_addr_o == base, "R2 pc vector", mem_addr_o, base);
                    chk(vbr_o == 0 && imask_o == 4'hF, "R4 init", {vbr_o[27:0], imask_o}, 32'hF);
                    chk(hold_o && !run_o, "R7 held", {hold_o, run_o}, 2'b10);
                    for (int w = 0; w < lp; w++) begin
                        @(negedge clk);
                        chk(mem_req_o && mem_addr_o == base, "R3 pc wait stable", mem_addr_o, base);
                        chk(pc_o == cur_pc, "R5 pc not early", pc_o, cur_pc);
                    end
                    respond(pcv);
                    chk(mem_req_o && mem_addr_o == base + 4, "R3 sp vector", mem_addr_o, base + 4);
                    chk(pc_o == cur_pc && sp_o == cur_sp && !run_o, "R5 no commit after first read", pc_o, cur_pc);
                    for (int w = 0; w < ls; w++) begin
                        @(negedge clk);
                        chk(mem_req_o && mem_addr_o == base + 4, "R3 sp wait stable", mem_addr_o, base + 4);
                        chk(hold_o, "R7 held in wait", hold_o, 1);
                    end
                    respond(spv);
                    chk(run_o, "R6 run pulse", run_o, 1);
                    chk(pc_o == pcv, "R5 pc commit", pc_o, pcv);
                    chk(sp_o == spv, "R5 sp commit", sp_o, spv);
                    chk(!hold_o && !mem_req_o, "R6 release", {hold_o, mem_req_o}, 0);
                    @(negedge clk);
                    chk(!run_o && !hold_o, "R6 single cycle", {run_o, hold_o}, 0);
                    chk(pc_o == pcv && sp_o == spv, "R5 values held", pc_o, pcv);
                    cur_pc = pcv;
                    cur_sp = spv;
                    iter++;
                end
            end
        end

        // R8 restart while the stack-pointer read is pending
        pulse_start(1'b0);
        respond(32'hAAAA_0000);
        chk(mem_addr_o == 32'h4, "R8 setup sp read", mem_addr_o, 32'h4);
        pulse_start(1'b1);
        chk(mem_req_o && mem_addr_o == 32'h8, "R8 restart to pc vector", mem_addr_o, 32'h8);
        chk(pc_o == cur_pc && hold_o && !run_o, "R8 no commit on restart", pc_o, cur_pc);
        respond(32'h3000_0008);
        chk(mem_addr_o == 32'hC, "R8 sp vector new cause", mem_addr_o, 32'hC);
        respond(32'h4000_000C);
        chk(run_o && pc_o == 32'h3000_0008, "R8 pc from restarted read", pc_o, 32'h3000_0008);
        chk(sp_o == 32'h4000_000C, "R8 sp from restarted read", sp_o, 32'h4000_000C);
        cur_pc = pc_o;
        cur_sp = sp_o;
        @(negedge clk);

        // R8 start collides with the stack-pointer response
        pulse_start(1'b1);
        respond(32'h5555_0008);
        start_i      = 1'b1;
        cause_i      = 1'b0;
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = 32'h6666_000C;
        @(negedge clk);
        start_i      = 1'b0;
        mem_rvalid_i = 1'b0;
        chk(!run_o && pc_o == cur_pc && sp_o == cur_sp, "R8 start beats response", pc_o, cur_pc);
        chk(mem_req_o && mem_addr_o == 32'h0, "R8 collide restart addr", mem_addr_o, 32'h0);
        respond(32'h7000_0000);
        respond(32'h7000_0004);
        chk(run_o && pc_o == 32'h7000_0000 && sp_o == 32'h7000_0004, "R8 collide commit", pc_o, 32'h7000_0000);
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule